// File: doc/BRIEF.md
# Display Fade Sequencer

This block produces the time-varying brightness scale factors for an LED matrix controller. It runs two fades that are timed separately. The global fade moves one 6-bit level across all 64 grayscale levels and applies to the whole display. The palette fade moves a second 6-bit scale that applies only to one selected duty-table entry. Both fades advance on a free-running millisecond tick. A 4-bit speed code sets how long each step lasts.

When a fade ends, it raises its own sticky completion flag. A scroll-completion event comes in from outside and sets a third flag. The three flags make up a read-only status word and are ORed onto one interrupt line. Software clears each flag with its own one-cycle clear pulse. The PWM stage downstream multiplies its duty values by the scale outputs. That stage is outside this block.

Top module: `fade_engine`

## Requirements
- R1: After reset, `g_level` and `p_scale` are 63 (full), `g_blank` is 0, `p_index` is 0 and `status` is 0. Whenever a fade's enable is low, its scale is 63.
- R2: While the global fade is enabled and has not started because `g_go` is low, `g_blank` is 1. `g_level` is held at the start point: 0 for fade-in (`g_dir`=0) and 63 for fade-out (`g_dir`=1). If `g_go` is already high when the fade is enabled, it starts without blanking.
- R3: A running fade steps once every 2×(code+1) cycles in which `ms_tick` is high, and changes its level by exactly one per step. Cycles in which `ms_tick` is low do not count toward a step.
- R4: A single global fade-in rises from 0 to 63. One further step period after reaching 63, it sets status bit 1 and then holds 63 with `g_blank` low. A full run therefore takes 64 step periods.
- R5: A global fade-out (`g_dir`=1) starts at 63 and falls by one per step to 0.
- R6: With `g_rep`=1, the global fade reverses direction at each end of the ramp after the same 64-period leg. It sets status bit 1 at every reversal.
- R7: The palette fade acts only when `p_sel` is 1 to 7. `p_index` then shows `p_sel`, and `p_scale` ramps from 0 to 63 for fade-in (or the reverse for fade-out). When it ends, status bit 2 is set. A `p_sel` of 0 leaves `p_index` at 0, `p_scale` at 63 and the flags untouched. The palette fade does not affect `g_level`.
- R8: Each flag stays set until its own clear pulse arrives. A clear pulse affects only its own flag. When a completion event and its clear pulse fall in the same cycle, the flag ends up set.
- R9: `status` bit 0 is the scroll flag, bit 1 the global fade flag and bit 2 the palette fade flag, with bits 7:3 always 0. `irq` is the OR of the three flags.
- R10: Dropping a fade's enable in the middle of a ramp returns its scale to 63 on the next cycle and resets its step timer. A later enable then begins a fresh full step period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-millisecond timebase strobe |
| g_en | input | 1 | Global fade enable |
| g_go | input | 1 | Global fade start |
| g_dir | input | 1 | Global direction: 0 fade-in, 1 fade-out |
| g_rep | input | 1 | Global mode: 0 single run, 1 repeating |
| g_speed | input | 4 | Global step length code |
| p_en | input | 1 | Palette fade enable |
| p_go | input | 1 | Palette fade start |
| p_dir | input | 1 | Palette direction: 0 fade-in, 1 fade-out |
| p_sel | input | 3 | Palette entry number, 0 means none |
| p_speed | input | 4 | Palette step length code |
| scroll_done | input | 1 | Scroll completion event pulse |
| clr_scroll | input | 1 | Clear pulse for the scroll flag |
| clr_fade | input | 1 | Clear pulse for the global fade flag |
| clr_pal | input | 1 | Clear pulse for the palette fade flag |
| g_level | output | 6 | Global brightness scale |
| g_blank | output | 1 | Display held dark awaiting start |
| p_index | output | 3 | Palette entry being scaled, 0 if none |
| p_scale | output | 6 | Scale for that palette entry |
| status | output | 8 | Flag status word |
| irq | output | 1 | Combined interrupt |

## Verification
Two events can land on the same clock edge: a fade's completion event and software's clear pulse for that fade's flag. A scroll event can arrive on that edge as well. The bench counts cycles exactly from the start edge of a fade-out. It places `clr_fade` and `scroll_done` high across the very edge on which the final step fires. The expected result is that the fade flag and the scroll flag are both set afterwards. The bench also checks that clearing one flag leaves the other flags unchanged.

// File: rtl/fade_pkg.sv
`timescale 1ns/1ps
package fade_pkg;
  typedef enum logic [1:0] {
    RAMP_OFF   = 2'd0,
    RAMP_ARMED = 2'd1,
    RAMP_RUN   = 2'd2,
    RAMP_DONE  = 2'd3
  } ramp_state_e;

  localparam int NUM_FLAGS = 3;
  localparam int FLAG_SCROLL = 0;
  localparam int FLAG_FADE   = 1;
  localparam int FLAG_PAL    = 2;
endpackage

// File: rtl/fade_step_timer.sv
`timescale 1ns/1ps
module fade_step_timer #(
  parameter int SPD_W = 4,
  parameter int UNIT  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [SPD_W-1:0] speed,
  output logic             step
);
  localparam int MAX_LEN = UNIT * (2 ** SPD_W);
  localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim  = CNT_W'(UNIT * (int'(speed) + 1) - 1);
  assign step = run && tick && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt >= lim) ? '0 : cnt + 1'b1;
    end
  end

  // R10: an idle ramp leaves the timer cleared
  a_r10_timer_cleared: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
  // R3: no tick, no progress
  a_r3_tick_gates: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(cnt));
endmodule

// File: rtl/fade_ramp.sv
`timescale 1ns/1ps
module fade_ramp
  import fade_pkg::*;
#(
  parameter int LVL_W     = 6,
  parameter bit REPEAT_OK = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             go,
  input  logic             dir,
  input  logic             rep,
  input  logic             step,
  output logic [LVL_W-1:0] lvl,
  output logic             armed,
  output logic             running,
  output logic             end_evt
);
  localparam logic [LVL_W-1:0] MAXL = '1;

  ramp_state_e      state;
  logic             cur_dir;
  logic             at_end;
  logic [LVL_W-1:0] start_lvl;

  assign start_lvl = dir ? MAXL : '0;
  assign at_end    = cur_dir ? (lvl == '0) : (lvl == MAXL);
  assign running   = (state == RAMP_RUN);
  assign armed     = (state == RAMP_ARMED);
  assign end_evt   = running && step && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RAMP_OFF;
      lvl     <= MAXL;
      cur_dir <= 1'b0;
    end else if (!en) begin
      state   <= RAMP_OFF;
      lvl     <= MAXL;
    end else begin
      case (state)
        RAMP_OFF, RAMP_ARMED: begin
          lvl     <= start_lvl;
          cur_dir <= dir;
          state   <= go ? RAMP_RUN : RAMP_ARMED;
        end
        RAMP_RUN: begin
          if (step) begin
            if (at_end) begin
              if (REPEAT_OK && rep) cur_dir <= ~cur_dir;
              else                  state   <= RAMP_DONE;
            end else if (cur_dir) begin
              lvl <= lvl - 1'b1;
            end else begin
              lvl <= lvl + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R1 / R10: disabled means full scale on the next cycle
  a_r10_off_full: assert property (@(posedge clk) disable iff (rst)
    !en |=> (lvl == MAXL));
  // R3: level only moves on a timer step
  a_r3_hold_between_steps: assert property (@(posedge clk) disable iff (rst)
    (en && running && !step) |=> $stable(lvl));
  // R4: a finished single run holds its end level
  a_r4_done_holds: assert property (@(posedge clk) disable iff (rst)
    (en && state == RAMP_DONE) |=> $stable(lvl));
endmodule

// File: rtl/fade_flags.sv
`timescale 1ns/1ps
module fade_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_evt,
  input  logic [NF-1:0] clr,
  output logic [NF-1:0] flags
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flags[i] <= 1'b0;
      else if (set_evt[i]) flags[i] <= 1'b1;
      else if (clr[i])     flags[i] <= 1'b0;
    end

    // R8: an event wins over a coincident clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
      set_evt[i] |=> flags[i]);
    // R8: sticky until its own clear
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !clr[i]) |=> flags[i]);
    a_r8_clear_works: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !set_evt[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/fade_engine.sv
`timescale 1ns/1ps
module fade_engine
  import fade_pkg::*;
#(
  parameter int LVL_W          = 6,
  parameter int SPD_W          = 4,
  parameter int PAL_W          = 3,
  parameter int TICKS_PER_UNIT = 2,
  parameter int STAT_W         = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_tick,
  input  logic              g_en,
  input  logic              g_go,
  input  logic              g_dir,
  input  logic              g_rep,
  input  logic [SPD_W-1:0]  g_speed,
  input  logic              p_en,
  input  logic              p_go,
  input  logic              p_dir,
  input  logic [PAL_W-1:0]  p_sel,
  input  logic [SPD_W-1:0]  p_speed,
  input  logic              scroll_done,
  input  logic              clr_scroll,
  input  logic              clr_fade,
  input  logic              clr_pal,
  output logic [LVL_W-1:0]  g_level,
  output logic              g_blank,
  output logic [PAL_W-1:0]  p_index,
  output logic [LVL_W-1:0]  p_scale,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  localparam logic [LVL_W-1:0] MAXL = '1;

  logic g_step, g_run, g_armed, g_end;
  logic p_step, p_run, p_armed, p_end;
  logic p_valid;
  logic [NUM_FLAGS-1:0] evt, clr, flags;

  assign p_valid = p_en && (p_sel != '0);

  fade_step_timer #(.SPD_W(SPD_W), .UNIT(TICKS_PER_UNIT)) u_g_timer (
    .clk(clk), .rst(rst), .run(g_run), .tick(ms_tick),
    .speed(g_speed), .step(g_step)
  );

  fade_ramp #(.LVL_W(LVL_W), .REPEAT_OK(1'b1)) u_g_ramp (
    .clk(clk), .rst(rst), .en(g_en), .go(g_go), .dir(g_dir), .rep(g_rep),
    .step(g_step), .lvl(g_level), .armed(g_armed), .running(g_run),
    .end_evt(g_end)
  );

  fade_step_timer #(.SPD_W(SPD_W), .UNIT(TICKS_PER_UNIT)) u_p_timer (
    .clk(clk), .rst(rst), .run(p_run), .tick(ms_tick),
    .speed(p_speed), .step(p_step)
  );

  fade_ramp #(.LVL_W(LVL_W), .REPEAT_OK(1'b0)) u_p_ramp (
    .clk(clk), .rst(rst), .en(p_valid), .go(p_go), .dir(p_dir), .rep(1'b0),
    .step(p_step), .lvl(p_scale), .armed(p_armed), .running(p_run),
    .end_evt(p_end)
  );

  assign g_blank = g_armed;

  always_ff @(posedge clk) begin
    if (rst) p_index <= '0;
    else     p_index <= p_valid ? p_sel : '0;
  end

  always_comb begin
    evt = '0;
    clr = '0;
    evt[FLAG_SCROLL] = scroll_done;
    evt[FLAG_FADE]   = g_end;
    evt[FLAG_PAL]    = p_end;
    clr[FLAG_SCROLL] = clr_scroll;
    clr[FLAG_FADE]   = clr_fade;
    clr[FLAG_PAL]    = clr_pal;
  end

  fade_flags #(.NF(NUM_FLAGS)) u_flags (
    .clk(clk), .rst(rst), .set_evt(evt), .clr(clr), .flags(flags)
  );

  assign status = {{(STAT_W-NUM_FLAGS){1'b0}}, flags};
  assign irq    = |flags;

  // R2: blanking only while the global fade is enabled
  a_r2_blank_needs_enable: assert property (@(posedge clk) disable iff (rst)
    !g_en |=> !g_blank);
  // R7: an invalid palette number leaves everything at rest
  a_r7_invalid_sel_idle: assert property (@(posedge clk) disable iff (rst)
    (p_sel == '0) |=> (p_index == '0 && p_scale == MAXL));
  // R7: the palette flag rises only when the palette ramp ends
  a_r7_pal_flag_source: assert property (@(posedge clk) disable iff (rst)
    $rose(status[FLAG_PAL]) |-> $past(p_end));
  // R9: interrupt follows the status word
  a_r9_irq_status: assert property (@(posedge clk) disable iff (rst)
    irq == (status != '0));
endmodule

// File: tb/test_fade_engine.sv
`timescale 1ns/1ps
module test_fade_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b1;
  logic g_en = 0, g_go = 0, g_dir = 0, g_rep = 0;
  logic [3:0] g_speed = 4'd1;
  logic p_en = 0, p_go = 0, p_dir = 0;
  logic [2:0] p_sel = 3'd0;
  logic [3:0] p_speed = 4'd0;
  logic scroll_done = 0, clr_scroll = 0, clr_fade = 0, clr_pal = 0;
  logic [5:0] g_level, p_scale;
  logic [2:0] p_index;
  logic [7:0] status;
  logic g_blank, irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct { string req; int sel; int val; } item_t;
  item_t sb_q[$];

  fade_engine i_fade_engine (
    .clk(clk), .rst(rst), .ms_tick(ms_tick),
    .g_en(g_en), .g_go(g_go), .g_dir(g_dir), .g_rep(g_rep), .g_speed(g_speed),
    .p_en(p_en), .p_go(p_go), .p_dir(p_dir), .p_sel(p_sel), .p_speed(p_speed),
    .scroll_done(scroll_done), .clr_scroll(clr_scroll), .clr_fade(clr_fade),
    .clr_pal(clr_pal), .g_level(g_level), .g_blank(g_blank), .p_index(p_index),
    .p_scale(p_scale), .status(status), .irq(irq)
  );

  always #2.5 clk = ~clk;

  function automatic int observe(int sel);
    case (sel)
      0: return int'(g_level);
      1: return int'(g_blank);
      2: return int'(p_index);
      3: return int'(p_scale);
      4: return int'(status);
      default: return int'(irq);
    endcase
  endfunction

  // monitor: pops expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        int act;
        it = sb_q.pop_front();
        act = observe(it.sel);
        n_run++;
        if (act != it.val) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, act, it.val);
        end
      end
    end
  end

  task automatic expect_v(string req, int sel, int val);
    item_t it;
    it.req = req; it.sel = sel; it.val = val;
    sb_q.push_back(it);
  endtask

  task automatic adv(int n);
    repeat (n) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    adv(3);
    rst = 1'b0;
    adv(1);
    // R1 and R9 reset state
    expect_v("R1", 0, 63); expect_v("R1", 1, 0); expect_v("R1", 2, 0);
    expect_v("R1", 3, 63); expect_v("R9", 4, 0); expect_v("R9", 5, 0);

    // global fade-in, speed code 1 -> 4 ticks per step
    g_speed = 4'd1; g_en = 1;
    adv(1); expect_v("R2", 1, 1); expect_v("R2", 0, 0);
    adv(5); expect_v("R2", 1, 1); expect_v("R2", 0, 0);
    g_go = 1;
    adv(1); expect_v("R2", 1, 0); expect_v("R4", 0, 0);
    adv(4); expect_v("R3", 0, 1);
    adv(3); expect_v("R3", 0, 1);
    adv(1); expect_v("R3", 0, 2);
    adv(247); expect_v("R4", 0, 63); expect_v("R4", 4, 0);
    adv(1); expect_v("R4", 4, 2); expect_v("R9", 5, 1);
    adv(10); expect_v("R4", 0, 63); expect_v("R4", 4, 2); expect_v("R4", 1, 0);
    clr_fade = 1; adv(1); clr_fade = 0;
    expect_v("R8", 4, 0); expect_v("R9", 5, 0);
    scroll_done = 1; adv(1); scroll_done = 0;
    expect_v("R9", 4, 1); expect_v("R9", 5, 1);
    clr_fade = 1; adv(1); clr_fade = 0;
    expect_v("R8", 4, 1);
    clr_scroll = 1; adv(1); clr_scroll = 0;
    expect_v("R8", 4, 0);

    // fade-out with go already high, then abort
    g_en = 0; adv(1); expect_v("R10", 0, 63); expect_v("R2", 1, 0);
    g_dir = 1; g_en = 1;
    adv(1); expect_v("R5", 0, 63); expect_v("R2", 1, 0);
    adv(4); expect_v("R5", 0, 62);
    adv(15); expect_v("R5", 0, 59);
    g_en = 0; adv(1); expect_v("R10", 0, 63);
    g_en = 1;
    adv(4); expect_v("R10", 0, 63);
    adv(1); expect_v("R10", 0, 62);
    adv(251); expect_v("R5", 0, 0); expect_v("R5", 4, 0);
    // final step, clear pulse and scroll event share one edge
    clr_fade = 1; scroll_done = 1;
    adv(1); clr_fade = 0; scroll_done = 0;
    expect_v("R8", 4, 3);
    clr_fade = 1; clr_scroll = 1; adv(1); clr_fade = 0; clr_scroll = 0;
    expect_v("R8", 4, 0);

    // repeating run, speed code 0 -> 2 ticks per step
    g_en = 0; adv(1);
    g_dir = 0; g_rep = 1; g_speed = 4'd0; g_en = 1;
    adv(1); expect_v("R6", 0, 0);
    adv(128); expect_v("R6", 0, 63); expect_v("R6", 4, 2);
    adv(2); expect_v("R6", 0, 62);
    clr_fade = 1; adv(1); clr_fade = 0;
    adv(1); expect_v("R8", 4, 0);
    adv(123); expect_v("R6", 0, 0); expect_v("R6", 4, 0);
    adv(1); expect_v("R6", 4, 2);
    adv(2); expect_v("R6", 0, 1);
    g_en = 0; g_rep = 0;
    clr_fade = 1; adv(1); clr_fade = 0;
    adv(1); expect_v("R8", 4, 0);

    // palette fade: invalid selection first
    p_en = 1; p_go = 1; p_dir = 0; p_speed = 4'd0; p_sel = 3'd0;
    adv(3); expect_v("R7", 2, 0); expect_v("R7", 3, 63); expect_v("R7", 4, 0);
    p_sel = 3'd3;
    adv(1); expect_v("R7", 2, 3); expect_v("R7", 3, 0);
    adv(2); expect_v("R7", 3, 1); expect_v("R7", 0, 63);
    adv(125); expect_v("R7", 3, 63); expect_v("R7", 4, 0);
    adv(1); expect_v("R9", 4, 4); expect_v("R9", 5, 1);
    clr_pal = 1; adv(1); clr_pal = 0;
    expect_v("R8", 4, 0);

    // tick gating on the palette fade-out
    p_en = 0; adv(1); expect_v("R1", 2, 0); expect_v("R1", 3, 63);
    p_dir = 1; ms_tick = 0; p_en = 1;
    adv(1); expect_v("R3", 3, 63);
    adv(10); expect_v("R3", 3, 63);
    ms_tick = 1;
    adv(1); expect_v("R3", 3, 63);
    adv(1); expect_v("R3", 3, 62);

    adv(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule